// File: doc/BRIEF.md
# Push-Button Debouncer with Settling Timer

This block turns the raw level of one mechanical push-button into a clean level for synchronous logic. The raw level first passes through a two-flop synchronizer. A three-state controller then drives the clean output high as soon as it sees a synchronized high level. It keeps that output high for a fixed settling window, so contact bounce cannot show up as a low glitch. A separate timeout counter measures the window.

When the window ends, the controller looks at the synchronized input. A low input sends it back to idle. A high input moves it to a held state, where it follows the input and drops the output on the first synchronized low. The window length is a parameter. A timer-active output shows when the counter is running.

Top module: `btn_debounce`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `btn_clean` and `tmr_active` are 0. Reset puts the controller in idle, clears the counter and timeout flag, and clears the synchronizer flops.
- R2: The raw input passes through exactly two synchronizer flops. From idle, `btn_clean` rises on the third rising clock edge after `btn_raw` goes high.
- R3: In idle, a synchronized high input moves the controller to the settling state on the next edge, and `btn_clean` goes to 1.
- R4: In the settling state, `btn_clean` stays 1 whatever the input does.
- R5: `tmr_active` is 1 exactly when the controller is in the settling state, and 0 in idle and held.
- R6: In the settling state the counter counts up by one each cycle until it reaches `THRESHOLD`, then sets the timeout flag. The controller therefore stays in settling for exactly `THRESHOLD`+2 cycles.
- R7: When the timeout flag is set, a synchronized low input returns the controller to idle (`btn_clean`=0), and a synchronized high input moves it to held (`btn_clean`=1).
- R8: In held, a synchronized low input returns the controller to idle on the next edge, so `btn_clean` falls three edges after `btn_raw` falls.
- R9: While `tmr_active` is 0, the counter and the timeout flag are cleared every cycle, so every new settling window has the full length of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_raw | input | 1 | Raw, asynchronous button level |
| btn_clean | output | 1 | Debounced button level (1 = pressed) |
| tmr_active | output | 1 | High while the settling timer is enabled |

## Verification
The bench drives bursts of random bounce at press and at release. On every cycle it checks that `btn_clean` never drops during settling; a design that left settling early or on a low sample would show a one-cycle low glitch. It measures the settling window, because an off-by-one in the counter compare or the flag register would lengthen or shorten it by a cycle. It also presses again right after a release, which catches a counter that is not cleared between windows. Directed runs check the three-edge latency at press and at release, and the two exits at timeout: low input to idle, high input to held.

// File: rtl/btn_deb_pkg.sv
package btn_deb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_HELD   = 2'd2
  } deb_state_t;
endpackage

// File: rtl/deb_sync.sv
module deb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

  // R2: last flop takes the previous value of the one before it
  a_r2_sync_shift: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> chain[STAGES-1] == $past(chain[STAGES-2]));
endmodule

// File: rtl/deb_timer.sv
module deb_timer #(
  parameter int THRESHOLD = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic done
);
  localparam int CW = $clog2(THRESHOLD + 1);
  localparam logic [CW-1:0] LIM = CW'(THRESHOLD);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      done <= 1'b0;
    end else if (cnt < LIM) begin
      cnt <= cnt + 1'b1;
    end else begin
      done <= 1'b1;
    end
  end

  // R9: disabled timer is cleared on the next edge
  a_r9_clear_when_off: assert property (@(posedge clk) disable iff (rst)
    !en |=> (cnt == '0) && !done);
  // R6: count never passes the threshold
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM);
  // R6: flag only rises once the threshold was reached
  a_r6_flag_after_limit: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(cnt) == LIM);
endmodule

// File: rtl/deb_fsm.sv
module deb_fsm
  import btn_deb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic x,
  input  logic tmo,
  output logic level,
  output logic tmr_en
);
  deb_state_t st, st_nx;

  always_comb begin
    st_nx = st;
    unique case (st)
      ST_IDLE:   if (x) st_nx = ST_SETTLE;
      ST_SETTLE: if (tmo) st_nx = x ? ST_HELD : ST_IDLE;
      ST_HELD:   if (!x) st_nx = ST_IDLE;
      default:   st_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_IDLE;
    else     st <= st_nx;
  end

  assign level  = (st != ST_IDLE);
  assign tmr_en = (st == ST_SETTLE);

  // R3: high input in idle starts a settling window
  a_r3_idle_to_settle: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && x) |=> st == ST_SETTLE);
  // R6: no exit from settling before timeout
  a_r6_no_early_exit: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SETTLE && !tmo) |=> st == ST_SETTLE);
  // R7: timeout exits chosen by input
  a_r7_exit_low: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SETTLE && tmo && !x) |=> st == ST_IDLE);
  a_r7_exit_high: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SETTLE && tmo && x) |=> st == ST_HELD);
  // R8: release from held
  a_r8_held_release: assert property (@(posedge clk) disable iff (rst)
    (st == ST_HELD && !x) |=> st == ST_IDLE);
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int THRESHOLD   = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic btn_raw,
  output logic btn_clean,
  output logic tmr_active
);
  logic btn_sync;
  logic tmo;
  logic tmr_en;

  deb_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(btn_raw), .q(btn_sync)
  );

  deb_fsm u_fsm (
    .clk(clk), .rst(rst), .x(btn_sync), .tmo(tmo),
    .level(btn_clean), .tmr_en(tmr_en)
  );

  deb_timer #(.THRESHOLD(THRESHOLD)) u_tmr (
    .clk(clk), .rst(rst), .en(tmr_en), .done(tmo)
  );

  assign tmr_active = tmr_en;

  // R5: timer-active never overlaps a low output
  a_r5_active_implies_high: assert property (@(posedge clk) disable iff (rst)
    tmr_active |-> btn_clean);
endmodule

// File: tb/tb_btn_debounce.sv
module tb_btn_debounce;
  localparam int THR = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic btn_raw = 1'b0;
  logic btn_clean, tmr_active;

  int total = 0;
  int bad = 0;

  btn_debounce #(.THRESHOLD(THR), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst(rst), .btn_raw(btn_raw),
    .btn_clean(btn_clean), .tmr_active(tmr_active)
  );

  always #2 clk = ~clk;

  // reference model (0 idle, 1 settling, 2 held)
  logic m_s1 = 0, m_s2 = 0, m_tf = 0;
  int   m_st = 0, m_cnt = 0;

  function automatic bit m_out(int s); return s != 0; endfunction
  function automatic bit m_en(int s);  return s == 1; endfunction

  task automatic model_step(input bit r, input bit rs);
    int nst;
    if (rs) begin
      m_s1 = 0; m_s2 = 0; m_st = 0; m_cnt = 0; m_tf = 0;
      return;
    end
    nst = m_st;
    case (m_st)
      0: if (m_s2) nst = 1;
      1: if (m_tf) nst = m_s2 ? 2 : 0;
      default: if (!m_s2) nst = 0;
    endcase
    if (!m_en(m_st)) begin m_cnt = 0; m_tf = 0; end
    else if (m_cnt < THR) m_cnt++;
    else m_tf = 1;
    m_s2 = m_s1; m_s1 = r; m_st = nst;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input bit r, input bit rs);
    @(negedge clk);
    chk(btn_clean == m_out(m_st),
        (m_st == 1) ? "R4" : (m_st == 2) ? "R7" : "R8",
        btn_clean, m_out(m_st));
    chk(tmr_active == m_en(m_st), "R5", tmr_active, m_en(m_st));
    if (m_st == 1) chk(btn_clean == 1'b1, "R4 glitch", btn_clean, 1);
    btn_raw = r; rst = rs;
    model_step(r, rs);
  endtask

  task automatic hold(input bit r, input int n);
    for (int i = 0; i < n; i++) drive(r, 0);
  endtask

  task automatic bounce(input int n);
    for (int i = 0; i < n; i++) drive(1'($urandom_range(0, 1)), 0);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int lat, win;
    void'($urandom(32'd20240611));
    // R1: reset state
    drive(0, 1); drive(1, 1); drive(1, 1);
    chk(btn_clean == 0 && tmr_active == 0, "R1 in reset", btn_clean, 0);
    drive(0, 0);
    chk(btn_clean == 0 && tmr_active == 0, "R1 after reset", btn_clean, 0);
    hold(0, 5);

    // R2/R3: press latency of three edges
    drive(1, 0); lat = 0;
    while (!btn_clean && lat < 10) begin drive(1, 0); lat++; end
    chk(lat == 3, "R2 press latency", lat, 3);

    // R6: settling window length, then R7 held
    win = tmr_active ? 1 : 0;
    while (tmr_active && win < 100) begin drive(1, 0); if (tmr_active) win++; end
    chk(win == THR + 2, "R6 window", win, THR + 2);
    chk(btn_clean == 1, "R7 to held", btn_clean, 1);
    hold(1, 4);

    // R8: release from held within three edges
    drive(0, 0); lat = 0;
    while (btn_clean && lat < 10) begin drive(0, 0); lat++; end
    chk(lat == 3, "R8 release latency", lat, 3);

    // R7: short press, low at timeout -> idle
    drive(1, 0); hold(0, THR + 8);
    chk(btn_clean == 0 && tmr_active == 0, "R7 exit low", btn_clean, 0);

    // R9: immediate re-press gets a full window
    hold(1, 3);
    win = 0;
    while (!tmr_active && win < 10) begin drive(1, 0); win++; end
    win = 1;
    while (tmr_active && win < 100) begin drive(1, 0); if (tmr_active) win++; end
    chk(win == THR + 2, "R9 fresh window", win, THR + 2);
    hold(0, 6);

    // random bouncing presses and releases
    for (int e = 0; e < 80; e++) begin
      bounce($urandom_range(0, 30));
      hold(1, $urandom_range(0, 40));
      bounce($urandom_range(0, 30));
      hold(0, $urandom_range(0, 30));
    end

    // R1: reset mid-window
    hold(1, 8); drive(1, 1); drive(0, 0);
    chk(btn_clean == 0 && tmr_active == 0, "R1 mid reset", btn_clean, 0);
    hold(0, 4);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule